// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block turns a fast peripheral clock into the timing grid of an I2C controller. A first stage divides the peripheral clock by one plus a 3-bit divisor. The result is a one-cycle internal tick, which the surrounding system keeps below 20 MHz. A second stage counts those ticks to form each SCL period. A period is a fixed base of 20 ticks, plus 8 ticks for each step of a 6-bit divisor, plus a programmable compensation count. The compensation count covers the bus rise time, the bus fall time and the internal delay, already expressed in ticks. Each period has a low half and a high half. When the length is odd, the spare tick goes to the low half.

A transfer begins when the enable input goes high. SCL first stays high for a setup delay while the data line settles. The delay is the 4-bit setup code plus 2 ticks, so code 0x0F gives 17 ticks. A one-cycle setup strobe marks the end of that delay, and SCL then falls for the first low phase.

The divider word is sampled only while idle and at the end of each SCL period. A write during a period therefore never shortens or stretches the phase in progress. When enable drops, the period in progress runs to its end, and SCL then stays high.

Top module: `scl_clock_divider`

## Requirements
- R1: During and after reset, with enable low, `scl_o` is 1 and `setup_strobe_o` and `period_start_o` are 0.
- R2: `tick_o` pulses once every (1 + D) peripheral clock cycles, where D is `div_cfg_i[2:0]`. An SCL phase of N ticks lasts N × (1 + D) peripheral cycles.
- R3: One SCL period lasts 20 + 8 × S + C ticks, where S is `div_cfg_i[8:3]` and C is `comp_cfg_i`.
- R4: The low phase of a period lasts ceil(P/2) ticks and the high phase lasts floor(P/2) ticks, where P is the period length.
- R5: After enable rises while idle, SCL stays high for (setup code + 2) ticks. `setup_strobe_o` is high in the peripheral cycle of the last of those ticks, and `scl_o` is 0 in the following cycle.
- R6: A change to `div_cfg_i` or `comp_cfg_i` during a transfer takes effect from the next period boundary. The period in progress keeps its old length and tick rate.
- R7: If enable drops during a low phase, that low phase and its high phase complete at full length. SCL then stays high, and no further period starts.
- R8: `period_start_o` pulses exactly once per low phase, in the cycle of the tick that begins it.
- R9: `scl_o` changes only in the peripheral cycle that follows a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Starts a transfer on rising while idle; dropping it ends the transfer at the next period boundary |
| div_cfg_i | input | 9 | Bits 2:0 first-stage divisor, bits 8:3 SCL step divisor |
| comp_cfg_i | input | 6 | Rise/fall compensation count in ticks |
| setup_cfg_i | input | 4 | First-bit setup code; delay is code + 2 ticks |
| tick_o | output | 1 | Internal tick, one peripheral cycle wide |
| scl_o | output | 1 | SCL level (1 = released high) |
| period_start_o | output | 1 | Pulse at the tick that begins each low phase |
| setup_strobe_o | output | 1 | Pulse at the last tick of the first-bit setup delay |

## Verification
The hardest situation to reach from the ports is a divider write that lands inside a running period. This includes writes that change the tick rate itself. The outcome is visible only as the length of the current phase and of the next one. The stimulus counts peripheral cycles from the start of the first low phase, writes the new divider word a few cycles in, and then times both periods in ticks and in peripheral cycles. A second situation is dropping enable a couple of cycles into the final low phase. The stimulus then watches SCL for two full periods, to see that no further period begins.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_LOW   = 2'd2,
    SQ_HIGH  = 2'd3
  } sq_state_e;

  // SCL period length in ticks: base + mul * step + comp
  function automatic int unsigned period_ticks(int unsigned base, int unsigned mul,
                                               int unsigned step, int unsigned comp);
    return base + mul * step + comp;
  endfunction

  // odd leftover tick goes to the low half
  function automatic int unsigned low_ticks(int unsigned per);
    return per - (per / 2);
  endfunction

  function automatic int unsigned high_ticks(int unsigned per);
    return per / 2;
  endfunction

  function automatic int unsigned setup_ticks(int unsigned code, int unsigned add);
    return code + add;
  endfunction

endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold #(
  parameter int PRE_W  = 3,
  parameter int STEP_W = 6,
  parameter int COMP_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [PRE_W+STEP_W-1:0] div_cfg_i,
  input  logic [COMP_W-1:0]       comp_cfg_i,
  output logic [PRE_W-1:0]        pre_q_o,
  output logic [STEP_W-1:0]       step_q_o,
  output logic [COMP_W-1:0]       comp_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q_o  <= '0;
      step_q_o <= '0;
      comp_q_o <= '0;
    end else if (load_i) begin
      pre_q_o  <= div_cfg_i[PRE_W-1:0];
      step_q_o <= div_cfg_i[PRE_W +: STEP_W];
      comp_q_o <= comp_cfg_i;
    end
  end

endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
  parameter int PRE_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] pre_i,
  output logic             tick_o
);

  logic [PRE_W-1:0] cnt_q;

  // >= keeps the counter bounded if the divisor is lowered while idle
  assign tick_o = (cnt_q >= pre_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + PRE_W'(1);
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tick_o) && (pre_i != '0) && $stable(pre_i)) |-> !tick_o); // R2

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_div_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] low_len_i,
  input  logic [CNT_W-1:0] high_len_i,
  input  logic [CNT_W-1:0] setup_len_i,
  output sq_state_e        state_o,
  output logic             scl_o,
  output logic             setup_strobe_o,
  output logic             boundary_o,
  output logic             period_start_o,
  output logic             load_o
);

  sq_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] setup_q;
  logic [CNT_W-1:0] limit;
  logic             at_last;
  logic             scl_q;

  always_comb begin
    unique case (state_q)
      SQ_SETUP: limit = setup_q;
      SQ_LOW:   limit = low_len_i;
      SQ_HIGH:  limit = high_len_i;
      default:  limit = '0;
    endcase
  end

  assign at_last        = (cnt_q == (limit - CNT_W'(1)));
  assign setup_strobe_o = (state_q == SQ_SETUP) && tick_i && at_last;
  assign boundary_o     = (state_q == SQ_HIGH) && tick_i && at_last;
  assign period_start_o = setup_strobe_o || (boundary_o && enable_i);
  assign load_o         = (state_q == SQ_IDLE) || boundary_o;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SQ_IDLE: begin
        cnt_d = '0;
        if (enable_i) state_d = SQ_SETUP;
      end
      SQ_SETUP: if (tick_i) begin
        if (at_last) begin
          state_d = SQ_LOW;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      SQ_LOW: if (tick_i) begin
        if (at_last) begin
          state_d = SQ_HIGH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      SQ_HIGH: if (tick_i) begin
        if (at_last) begin
          state_d = enable_i ? SQ_LOW : SQ_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      setup_q <= '0;
      scl_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      scl_q   <= (state_d != SQ_LOW);
      if ((state_q == SQ_IDLE) && enable_i) setup_q <= setup_len_i;
    end
  end

  assign state_o = state_q;
  assign scl_o   = scl_q;

  AST_SCL_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o != $past(scl_o)) |-> $past(tick_i)); // R9

  AST_SETUP_THEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_strobe_o |=> !scl_o); // R5

  AST_LOW_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_LOW) |-> (cnt_q < low_len_i)); // R4

  AST_LOW_NEVER_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_LOW) |=> (state_q != SQ_IDLE)); // R7

endmodule

// File: rtl/scl_clock_divider.sv
module scl_clock_divider
  import scl_div_pkg::*;
#(
  parameter int PRE_W     = 3,
  parameter int STEP_W    = 6,
  parameter int COMP_W    = 6,
  parameter int SETUP_W   = 4,
  parameter int BASE_CYC  = 20,
  parameter int STEP_MUL  = 8,
  parameter int SETUP_ADD = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    enable_i,
  input  logic [PRE_W+STEP_W-1:0] div_cfg_i,
  input  logic [COMP_W-1:0]       comp_cfg_i,
  input  logic [SETUP_W-1:0]      setup_cfg_i,
  output logic                    tick_o,
  output logic                    scl_o,
  output logic                    period_start_o,
  output logic                    setup_strobe_o
);

  localparam int PER_MAX   = BASE_CYC + ((1 << STEP_W) - 1) * STEP_MUL + ((1 << COMP_W) - 1);
  localparam int SETUP_MAX = ((1 << SETUP_W) - 1) + SETUP_ADD;
  localparam int PER_W     = $clog2(PER_MAX + 1);
  localparam int SLEN_W    = $clog2(SETUP_MAX + 1);
  localparam int CNT_W     = (PER_W > SLEN_W) ? PER_W : SLEN_W;

  logic [PRE_W-1:0]  pre_q;
  logic [STEP_W-1:0] step_q;
  logic [COMP_W-1:0] comp_q;
  logic              load;
  logic              boundary;
  sq_state_e         state;
  logic [CNT_W-1:0]  per_len, low_len, high_len, setup_len;

  scl_cfg_hold #(
    .PRE_W (PRE_W),
    .STEP_W(STEP_W),
    .COMP_W(COMP_W)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .div_cfg_i (div_cfg_i),
    .comp_cfg_i(comp_cfg_i),
    .pre_q_o   (pre_q),
    .step_q_o  (step_q),
    .comp_q_o  (comp_q)
  );

  scl_tick_gen #(
    .PRE_W(PRE_W)
  ) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pre_i (pre_q),
    .tick_o(tick_o)
  );

  assign per_len   = CNT_W'(period_ticks(BASE_CYC, STEP_MUL, 32'(step_q), 32'(comp_q)));
  assign low_len   = CNT_W'(low_ticks(32'(per_len)));
  assign high_len  = CNT_W'(high_ticks(32'(per_len)));
  assign setup_len = CNT_W'(setup_ticks(32'(setup_cfg_i), SETUP_ADD));

  scl_phase_seq #(
    .CNT_W(CNT_W)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_o),
    .enable_i      (enable_i),
    .low_len_i     (low_len),
    .high_len_i    (high_len),
    .setup_len_i   (setup_len),
    .state_o       (state),
    .scl_o         (scl_o),
    .setup_strobe_o(setup_strobe_o),
    .boundary_o    (boundary),
    .period_start_o(period_start_o),
    .load_o        (load)
  );

  AST_CFG_FROZEN_IN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == SQ_LOW) && ($past(state) == SQ_LOW))
      |-> ($stable(step_q) && $stable(comp_q) && $stable(pre_q))); // R6

  AST_BOUNDARY_IN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary |-> (scl_o && tick_o)); // R3

endmodule

// File: tb/scl_clock_divider_test.sv
module scl_clock_divider_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [8:0] div = '0;
  logic [5:0] comp = '0;
  logic [3:0] setup = '0;
  logic       tick, scl, pstart, sstb;

  int  tests = 0;
  int  fails = 0;
  bit  done = 1'b0;
  int  per_cnt = 0;
  int  r9_bad = 0;
  logic prev_scl = 1'b1;
  logic prev_tick = 1'b0;

  scl_clock_divider uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .enable_i      (en),
    .div_cfg_i     (div),
    .comp_cfg_i    (comp),
    .setup_cfg_i   (setup),
    .tick_o        (tick),
    .scl_o         (scl),
    .period_start_o(pstart),
    .setup_strobe_o(sstb)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pstart) per_cnt++;
      if ((scl !== prev_scl) && !prev_tick) r9_bad++;
    end
    prev_scl  = scl;
    prev_tick = tick;
  end

  function automatic int exp_period(int step, int c);
    return (step << 3) + c + 20;
  endfunction
  function automatic int exp_low(int p);
    return (p + 1) / 2;
  endfunction
  function automatic int exp_high(int p);
    return (p - (p % 2)) / 2;
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic tick_gap(int pre);
    int c;
    @(negedge clk);
    div[2:0] = pre[2:0];
    repeat (10) @(negedge clk);
    while (!tick) @(negedge clk);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!tick);
    check(c == pre + 1, "R2 idle tick spacing", c, pre + 1);
  endtask

  task automatic run_xfer(int pre, int step, int cc, int stp, int nper,
                          bit chg, int npre, int nstep, int ncomp);
    int t, c, th, ch, p, lo, hi, base, cp, cs, ccur, bad;
    @(negedge clk);
    en    = 1'b0;
    div   = {step[5:0], pre[2:0]};
    comp  = cc[5:0];
    setup = stp[3:0];
    repeat (3) @(negedge clk);
    base = per_cnt;
    en   = 1'b1;
    t    = 0;
    c    = 0;
    do begin
      @(negedge clk);
      if (tick) t++;
      c++;
    end while (!sstb && c < 100000);
    check(t == stp + 2, "R5 setup delay ticks", t, stp + 2);
    @(negedge clk);
    check(scl == 1'b0, "R5 scl low after setup strobe", int'(scl), 0);
    cp = pre; cs = step; ccur = cc;
    for (int k = 0; k < nper; k++) begin
      if (k > 0 && chg) begin
        cp = npre; cs = nstep; ccur = ncomp;
      end
      p  = exp_period(cs, ccur);
      lo = exp_low(p);
      hi = exp_high(p);
      t = 0; c = 0;
      while (scl == 1'b0 && c < 100000) begin
        if (tick) t++;
        c++;
        if (chg && k == 0 && c == 3) begin
          div  = {nstep[5:0], npre[2:0]};
          comp = ncomp[5:0];
        end
        if (k == nper - 1 && c == 2) en = 1'b0;
        @(negedge clk);
      end
      check(t == lo, chg ? "R6 R4 low ticks" : "R4 low ticks", t, lo);
      check(c == lo * (cp + 1), "R2 low phase cycles", c, lo * (cp + 1));
      if (k == nper - 1) begin
        bad = 0;
        repeat (2 * p * (cp + 1) + 8) begin
          if (scl != 1'b1) bad++;
          @(negedge clk);
        end
        check(bad == 0, "R7 scl held high after enable drop", bad, 0);
        check(per_cnt - base == nper, "R8 period start pulses", per_cnt - base, nper);
      end else begin
        th = 0; ch = 0;
        while (scl == 1'b1 && ch < 100000) begin
          if (tick) th++;
          ch++;
          @(negedge clk);
        end
        check(th == hi, "R4 high ticks", th, hi);
        check(t + th == p, chg ? "R6 R3 period ticks" : "R3 period ticks", t + th, p);
        check(ch == hi * (cp + 1), "R2 high phase cycles", ch, hi * (cp + 1));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(scl == 1'b1, "R1 scl in reset", int'(scl), 1);
    check(sstb == 1'b0, "R1 setup strobe in reset", int'(sstb), 0);
    check(pstart == 1'b0, "R1 period start in reset", int'(pstart), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(scl == 1'b1 && !sstb && !pstart, "R1 idle after reset", int'(scl), 1);

    for (int d = 0; d < 8; d++) tick_gap(d);

    // directed corners
    run_xfer(0, 0, 0, 0, 3, 1'b0, 0, 0, 0);
    run_xfer(7, 63, 63, 15, 2, 1'b0, 0, 0, 0);
    run_xfer(1, 2, 1, 15, 3, 1'b0, 0, 0, 0);
    run_xfer(2, 5, 3, 4, 3, 1'b1, 0, 10, 7);
    run_xfer(0, 1, 0, 3, 3, 1'b1, 3, 0, 9);

    // random
    for (int i = 0; i < 10; i++) begin
      int rp, rs, rc, rt, rn;
      rp = int'($urandom % 4);
      rs = int'($urandom % 32);
      rc = int'($urandom % 32);
      rt = int'($urandom % 16);
      rn = 2 + int'($urandom % 2);
      run_xfer(rp, rs, rc, rt, rn, 1'b0, 0, 0, 0);
    end

    check(r9_bad == 0, "R9 scl change only after tick", r9_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule